// File: doc/BRIEF.md
# Dual-Copy Sticky Error Status Bank

This block records monitored events in two independent status copies. The management-side copy serves a management controller and the host-side copy serves the host. Each event has an active-high level input. While an event is active and not masked, it sets its bit in both copies. The bit then stays set after the event goes away, until software clears it.

Clearing uses write-one-to-clear. Each copy clears on its own, and a clear only succeeds for a bit whose event is no longer active. A legacy mode makes a read of the management copy act as a read-to-clear. The host copy always keeps plain read semantics.

Masking comes from two sources, and both apply to both copies:
- a per-bit mask register;
- for the voltage events, which are the lowest `NV` bits, a high limit left at all-ones.

A mask blocks the setting of a bit but never erases a bit that is already set. A registered alert reports any set, unmasked bit in the management copy.

Top module: `err_status_dual`

## Requirements
- R1: An event that is active and unmasked at a clock edge sets its bit in both copies at that edge, and the bit stays set after the event drops.
- R2: A write to address 0 (management) or address 1 (host) clears each bit position written as 1, provided its event is inactive. Bits written as 0 are unchanged.
- R3: In any cycle where a bit's event is active, that bit is not cleared, whether the clear comes from a write or from a read-to-clear.
- R4: A clear of one copy never changes the other copy.
- R5: Address 3 bit 0 is the legacy-mode flag. While it is 1, a read of address 0 returns the current value and then clears every bit whose event is inactive. Reads of address 1 never clear anything, and reads of address 0 never clear anything while the flag is 0.
- R6: Write-one-to-clear on address 0 still works while legacy mode is on.
- R7: The mask register is at address 2, with bit i masking event i. An event whose mask bit is 1 sets its bit in neither copy.
- R8: Setting a mask bit leaves an already set status bit set.
- R9: Events 0..NV-1 are voltage events. Each has an 8-bit high limit at address 4+i, which resets to 8'hFF. While a limit equals 8'hFF, its event is masked exactly as in R7. Any other value leaves the event unmasked.
- R10: `alert_o` is a register. It is 1 at the edge after a cycle in which some management-copy bit is set and not masked by R7 or R9, and it is 0 otherwise.
- R11: After reset, both copies, the mask and the mode flag are 0, every limit is 8'hFF, and `alert_o` is 0.
- R12: `acc_rdata_o` shows, without delay, the register selected by `acc_addr_i`. Limits and the mode flag are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N | Active-high event levels, bit i is event i |
| acc_valid_i | input | 1 | Register access strobe |
| acc_write_i | input | 1 | 1 for a write, 0 for a read |
| acc_addr_i | input | ADDR_W | Register address (0 management, 1 host, 2 mask, 3 mode, 4+i limit i) |
| acc_wdata_i | input | N | Write data |
| acc_rdata_o | output | N | Read data of the addressed register |
| alert_o | output | 1 | Registered alert |

## Verification
Two functions can fall in the same cycle: setting a bit because its event is active, and clearing that same bit through a write-one-to-clear or a legacy read-to-clear. The bench provokes this by holding an event high during the cycle that carries the clear. It also raises one event while a read-to-clear removes a different, inactive bit. Every case is judged by a later read: a bit whose event was active must still be set, and a bit whose event was inactive must be gone.

// File: rtl/err_stat_pkg.sv
package err_stat_pkg;
  localparam int ADR_MGMT = 0;
  localparam int ADR_HOST = 1;
  localparam int ADR_MASK = 2;
  localparam int ADR_CTRL = 3;
  localparam int ADR_LIM0 = 4;
  localparam int CTRL_LEGACY_BIT = 0;
  localparam int NUM_COPIES = 2;

  typedef enum int {COPY_MGMT = 0, COPY_HOST = 1} copy_e;
endpackage

// File: rtl/ers_copy.sv
module ers_copy #(
  parameter int N = 8,
  parameter bit RTC_CAPABLE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] emask,
  input  logic [N-1:0] wr_clr,
  input  logic         rd_hit,
  input  logic         rtc_en,
  output logic [N-1:0] status_q
);
  // Sticky update: set from unmasked events, clear only where event is idle.
  function automatic logic [N-1:0] next_status(
    input logic [N-1:0] cur, input logic [N-1:0] ev,
    input logic [N-1:0] msk, input logic [N-1:0] clr);
    logic [N-1:0] setv, clr_ok;
    setv   = ev & ~msk;
    clr_ok = clr & ~ev;
    return (cur | setv) & ~clr_ok;
  endfunction

  logic [N-1:0] rd_clr;
  logic [N-1:0] clr_req;

  generate
    if (RTC_CAPABLE) begin : g_rtc
      assign rd_clr = {N{rd_hit & rtc_en}};
    end else begin : g_nortc
      logic unused_rd;
      assign unused_rd = rd_hit ^ rtc_en;
      assign rd_clr = '0;
    end
  endgenerate

  assign clr_req = wr_clr | rd_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= next_status(status_q, evt, emask, clr_req);
  end
endmodule

// File: rtl/ers_cfg_regs.sv
module ers_cfg_regs #(
  parameter int N  = 8,
  parameter int NV = 4,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_we,
  input  logic          mode_we,
  input  logic [NV-1:0] lim_we,
  input  logic [N-1:0]  wdata,
  output logic [N-1:0]  mask_q,
  output logic          legacy_q,
  output logic [LW-1:0] lim_q [NV],
  output logic [N-1:0]  eff_mask
);
  import err_stat_pkg::*;

  function automatic logic lim_disables(input logic [LW-1:0] lim);
    return &lim;
  endfunction

  logic [N-1:0] volt_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      legacy_q <= 1'b0;
    end else begin
      if (mask_we) mask_q   <= wdata;
      if (mode_we) legacy_q <= wdata[CTRL_LEGACY_BIT];
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NV; gi++) begin : g_lim
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          lim_q[gi] <= '1;
        else if (lim_we[gi]) lim_q[gi] <= wdata[LW-1:0];
      end
      assign volt_mask[gi] = lim_disables(lim_q[gi]);
    end
    for (gi = NV; gi < N; gi++) begin : g_nolim
      assign volt_mask[gi] = 1'b0;
    end
  endgenerate

  assign eff_mask = mask_q | volt_mask;
endmodule

// File: rtl/ers_alert.sv
module ers_alert #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status,
  input  logic [N-1:0] emask,
  output logic         alert_q
);
  function automatic logic any_live(input logic [N-1:0] st, input logic [N-1:0] m);
    return |(st & ~m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alert_q <= 1'b0;
    else        alert_q <= any_live(status, emask);
  end
endmodule

// File: rtl/err_status_dual.sv
module err_status_dual #(
  parameter int N  = 8,
  parameter int NV = 4,
  parameter int LW = 8,
  localparam int ADDR_W = $clog2(4 + NV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      evt_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [N-1:0]      acc_wdata_i,
  output logic [N-1:0]      acc_rdata_o,
  output logic              alert_o
);
  import err_stat_pkg::*;

  logic wr_hit, rd_hit;
  logic sel_mgmt, sel_host, sel_mask, sel_ctrl;
  logic [NV-1:0] sel_lim;
  logic [N-1:0] copy_q [NUM_COPIES];
  logic [N-1:0] mgmt_q, host_q;
  logic [N-1:0] mask_q, eff_mask;
  logic         legacy_q;
  logic [LW-1:0] lim_q [NV];

  assign wr_hit   = acc_valid_i & acc_write_i;
  assign rd_hit   = acc_valid_i & ~acc_write_i;
  assign sel_mgmt = acc_addr_i == ADDR_W'(ADR_MGMT);
  assign sel_host = acc_addr_i == ADDR_W'(ADR_HOST);
  assign sel_mask = acc_addr_i == ADDR_W'(ADR_MASK);
  assign sel_ctrl = acc_addr_i == ADDR_W'(ADR_CTRL);

  genvar gi;
  generate
    for (gi = 0; gi < NV; gi++) begin : g_sel
      assign sel_lim[gi] = acc_addr_i == ADDR_W'(ADR_LIM0 + gi);
    end

    for (gi = 0; gi < NUM_COPIES; gi++) begin : g_copy
      logic csel;
      assign csel = (gi == COPY_MGMT) ? sel_mgmt : sel_host;
      ers_copy #(.N(N), .RTC_CAPABLE(gi == COPY_MGMT)) u_copy (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_i),
        .emask   (eff_mask),
        .wr_clr  ((wr_hit & csel) ? acc_wdata_i : '0),
        .rd_hit  (rd_hit & csel),
        .rtc_en  (legacy_q),
        .status_q(copy_q[gi])
      );
    end
  endgenerate

  assign mgmt_q = copy_q[COPY_MGMT];
  assign host_q = copy_q[COPY_HOST];

  ers_cfg_regs #(.N(N), .NV(NV), .LW(LW)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (wr_hit & sel_mask),
    .mode_we (wr_hit & sel_ctrl),
    .lim_we  (sel_lim & {NV{wr_hit}}),
    .wdata   (acc_wdata_i),
    .mask_q  (mask_q),
    .legacy_q(legacy_q),
    .lim_q   (lim_q),
    .eff_mask(eff_mask)
  );

  ers_alert #(.N(N)) u_alert (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (mgmt_q),
    .emask  (eff_mask),
    .alert_q(alert_o)
  );

  always_comb begin
    acc_rdata_o = '0;
    if (sel_mgmt)      acc_rdata_o = mgmt_q;
    else if (sel_host) acc_rdata_o = host_q;
    else if (sel_mask) acc_rdata_o = mask_q;
    else if (sel_ctrl) acc_rdata_o[CTRL_LEGACY_BIT] = legacy_q;
    else begin
      for (int i = 0; i < NV; i++)
        if (sel_lim[i]) acc_rdata_o[LW-1:0] = lim_q[i];
    end
  end
endmodule

// File: rtl/err_status_dual_chk.sv
module err_status_dual_chk #(
  parameter int N  = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      evt_i,
  input logic              acc_valid_i,
  input logic              acc_write_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic [N-1:0]      eff_mask,
  input logic [N-1:0]      mgmt_q,
  input logic [N-1:0]      host_q,
  input logic              alert_o
);
  import err_stat_pkg::*;

  logic host_acc;
  assign host_acc = acc_valid_i & (acc_addr_i == ADDR_W'(ADR_HOST));

  assert_sticky_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & ~eff_mask)) |=>
      (((mgmt_q & host_q) & $past(evt_i & ~eff_mask)) == $past(evt_i & ~eff_mask)));

  assert_active_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mgmt_q & evt_i)) |=> ((mgmt_q & $past(mgmt_q & evt_i)) == $past(mgmt_q & evt_i)));

  assert_host_clear_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_acc & acc_write_i) |=>
      (mgmt_q == ($past(mgmt_q) | $past(evt_i & ~eff_mask))));

  assert_host_read_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_acc & !acc_write_i) |=> ((host_q & $past(host_q)) == $past(host_q)));

  assert_mask_blocks_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((mgmt_q & ~$past(mgmt_q)) & ~$past(evt_i & ~eff_mask)) == '0));

  assert_alert_registered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (alert_o == $past(|(mgmt_q & ~eff_mask))));
endmodule

bind err_status_dual err_status_dual_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_i      (evt_i),
  .acc_valid_i(acc_valid_i),
  .acc_write_i(acc_write_i),
  .acc_addr_i (acc_addr_i),
  .eff_mask   (eff_mask),
  .mgmt_q     (mgmt_q),
  .host_q     (host_q),
  .alert_o    (alert_o)
);

// File: tb/tb_err_status_dual.sv
module tb_err_status_dual;
  localparam int N = 8;
  localparam logic [1:0] OP_I = 2'd0, OP_W = 2'd1, OP_R = 2'd2;

  typedef struct packed {
    logic [7:0] evt;
    logic [1:0] op;
    logic [2:0] addr;
    logic [7:0] wd;
    logic [7:0] exp;
    logic [3:0] req;
  } row_t;

  localparam int NROWS = 49;
  localparam row_t TBL [NROWS] = '{
    '{8'h10, OP_I, 3'd0, 8'h00, 8'h00, 4'd1},  // R1 set
    '{8'h00, OP_R, 3'd0, 8'h00, 8'h10, 4'd1},  // R1 sticky
    '{8'h00, OP_R, 3'd1, 8'h00, 8'h10, 4'd1},  // R1 host too
    '{8'h10, OP_W, 3'd0, 8'h10, 8'h00, 4'd3},  // R3 clear while active
    '{8'h00, OP_R, 3'd0, 8'h00, 8'h10, 4'd3},
    '{8'h00, OP_W, 3'd0, 8'h00, 8'h00, 4'd2},  // R2 zero write
    '{8'h00, OP_R, 3'd0, 8'h00, 8'h10, 4'd2},
    '{8'h00, OP_W, 3'd0, 8'h10, 8'h00, 4'd2},
    '{8'h00, OP_R, 3'd0, 8'h00, 8'h00, 4'd2},
    '{8'h00, OP_R, 3'd1, 8'h00, 8'h10, 4'd4},  // R4
    '{8'h00, OP_W, 3'd1, 8'h10, 8'h00, 4'd4},
    '{8'h00, OP_R, 3'd1, 8'h00, 8'h00, 4'd4},
    '{8'h00, OP_W, 3'd2, 8'h20, 8'h00, 4'd7},  // R7
    '{8'h30, OP_I, 3'd0, 8'h00, 8'h00, 4'd7},
    '{8'h00, OP_R, 3'd0, 8'h00, 8'h10, 4'd7},
    '{8'h00, OP_R, 3'd1, 8'h00, 8'h10, 4'd7},
    '{8'h00, OP_R, 3'd2, 8'h00, 8'h20, 4'd12}, // R12
    '{8'h00, OP_W, 3'd2, 8'h30, 8'h00, 4'd8},  // R8
    '{8'h00, OP_R, 3'd0, 8'h00, 8'h10, 4'd8},
    '{8'h00, OP_W, 3'd2, 8'h00, 8'h00, 4'd8},
    '{8'h00, OP_W, 3'd0, 8'h10, 8'h00, 4'd2},
    '{8'h00, OP_W, 3'd1, 8'h10, 8'h00, 4'd2},
    '{8'h00, OP_W, 3'd3, 8'h01, 8'h00, 4'd5},  // R5 legacy on
    '{8'h00, OP_R, 3'd3, 8'h00, 8'h01, 4'd12},
    '{8'h40, OP_I, 3'd0, 8'h00, 8'h00, 4'd5},
    '{8'h80, OP_R, 3'd0, 8'h00, 8'h40, 4'd5},  // R5 read-clear, set same cycle
    '{8'h80, OP_R, 3'd0, 8'h00, 8'h80, 4'd3},  // R3 read-clear blocked
    '{8'h00, OP_R, 3'd0, 8'h00, 8'h80, 4'd5},
    '{8'h00, OP_R, 3'd0, 8'h00, 8'h00, 4'd5},
    '{8'h00, OP_R, 3'd1, 8'h00, 8'hC0, 4'd5},
    '{8'h00, OP_R, 3'd1, 8'h00, 8'hC0, 4'd5},
    '{8'h10, OP_I, 3'd0, 8'h00, 8'h00, 4'd6},  // R6
    '{8'h00, OP_W, 3'd0, 8'h10, 8'h00, 4'd6},
    '{8'h00, OP_R, 3'd0, 8'h00, 8'h00, 4'd6},
    '{8'h00, OP_R, 3'd1, 8'h00, 8'hD0, 4'd6},
    '{8'h00, OP_W, 3'd3, 8'h00, 8'h00, 4'd5},
    '{8'h00, OP_W, 3'd1, 8'hFF, 8'h00, 4'd2},
    '{8'h00, OP_R, 3'd1, 8'h00, 8'h00, 4'd2},
    '{8'h01, OP_I, 3'd0, 8'h00, 8'h00, 4'd9},  // R9 limit at FF
    '{8'h00, OP_R, 3'd0, 8'h00, 8'h00, 4'd9},
    '{8'h00, OP_R, 3'd4, 8'h00, 8'hFF, 4'd9},
    '{8'h00, OP_W, 3'd4, 8'h80, 8'h00, 4'd9},
    '{8'h01, OP_I, 3'd0, 8'h00, 8'h00, 4'd9},
    '{8'h00, OP_R, 3'd0, 8'h00, 8'h01, 4'd9},
    '{8'h00, OP_R, 3'd1, 8'h00, 8'h01, 4'd9},
    '{8'h00, OP_R, 3'd4, 8'h00, 8'h80, 4'd12},
    '{8'h00, OP_W, 3'd0, 8'h01, 8'h00, 4'd2},
    '{8'h00, OP_W, 3'd1, 8'h01, 8'h00, 4'd2},
    '{8'h00, OP_R, 3'd7, 8'h00, 8'hFF, 4'd9}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] evt = '0, awd = '0, rd;
  logic av = 1'b0, aw = 1'b0, alert;
  logic [2:0] aa = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  err_status_dual dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .acc_valid_i(av),
    .acc_write_i(aw), .acc_addr_i(aa), .acc_wdata_i(awd),
    .acc_rdata_o(rd), .alert_o(alert)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [7:0] e, input logic [1:0] op,
                       input logic [2:0] a, input logic [7:0] w);
    @(negedge clk);
    evt = e; av = (op != OP_I); aw = (op == OP_W); aa = a; awd = w;
    #1;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    drive(8'h00, OP_R, a, 8'h00);
    chk(req, rd, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 alert", {7'd0, alert}, 8'h00);
    rst_n = 1'b1;
    rd_chk("R11 mgmt", 3'd0, 8'h00);
    rd_chk("R11 host", 3'd1, 8'h00);
    rd_chk("R11 mask", 3'd2, 8'h00);
    rd_chk("R11 mode", 3'd3, 8'h00);
    rd_chk("R11 limit", 3'd5, 8'hFF);

    for (int i = 0; i < NROWS; i++) begin
      drive(TBL[i].evt, TBL[i].op, TBL[i].addr, TBL[i].wd);
      if (TBL[i].op == OP_R)
        chk($sformatf("R%0d row %0d", TBL[i].req, i), rd, TBL[i].exp);
    end

    // Alert latency, masking of a set bit, host-only state (R10, R8)
    drive(8'h10, OP_I, 3'd0, 8'h00);
    drive(8'h00, OP_I, 3'd0, 8'h00);
    chk("R10 latency low", {7'd0, alert}, 8'h00);
    drive(8'h00, OP_W, 3'd2, 8'h10);
    chk("R10 alert high", {7'd0, alert}, 8'h01);
    drive(8'h00, OP_I, 3'd0, 8'h00);
    chk("R10 mask lag", {7'd0, alert}, 8'h01);
    drive(8'h00, OP_I, 3'd0, 8'h00);
    chk("R8 alert masked", {7'd0, alert}, 8'h00);
    rd_chk("R8 bit kept", 3'd0, 8'h10);
    drive(8'h00, OP_W, 3'd2, 8'h00);
    drive(8'h00, OP_I, 3'd0, 8'h00);
    drive(8'h00, OP_I, 3'd0, 8'h00);
    chk("R10 unmasked again", {7'd0, alert}, 8'h01);
    drive(8'h00, OP_W, 3'd0, 8'h10);
    drive(8'h00, OP_I, 3'd0, 8'h00);
    drive(8'h00, OP_I, 3'd0, 8'h00);
    chk("R10 host only", {7'd0, alert}, 8'h00);
    rd_chk("R4 host left", 3'd1, 8'h10);

    // Reset again with state present (R11)
    drive(8'h00, OP_W, 3'd5, 8'h12);
    @(negedge clk); rst_n = 1'b0; av = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R11 host after reset", 3'd1, 8'h00);
    rd_chk("R11 limit after reset", 3'd5, 8'hFF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule